// File: doc/BRIEF.md
# Branch clock power-down controller

This block governs the enables of a set of branch clocks, arranged as a fixed number of branches under each of several base clocks. Each branch carries two configuration inputs: a run bit that asks for the clock, and a wake-up option bit that marks the branch as one that a global power-down may stop. Software reaches two registers over a simple write/read bus. One holds a single power-down bit. The other is a read-only status word with one bit per base clock.

When the power-down bit is set, every branch whose wake-up option is on loses its enable. Branches without the option keep running. The stopped clocks come back in two cases: software writes zero to the bit, or an external wake-up interrupt rises. In the second case the hardware clears the bit itself. The wake-up line is asynchronous, so the block brings it through a synchroniser and reacts to its rising edge only.

The status word shows, for each base clock, whether any branch under it still has an effective enable. A zero tells software that the base clock can be switched off safely. Branch b belongs to base b / BR_PER_BASE (integer division).

Top module: `brclk_pwrdn_ctrl`

## Requirements
- R1: The power-mode register sits at byte offset 0x0. Bit 0 is the power-down bit. Bits 31..1 always read 0, and a write affects only bit 0.
- R2: While power-down is 1, a branch with its wake-up option at 1 has its enable output at 0. A branch with its wake-up option at 0 has its enable output equal to its run bit.
- R3: While power-down is 0, every branch enable output equals its run bit.
- R4: A rising edge on the wake-up input passes through a two-stage synchroniser. Power-down reads 0 after the third rising clock edge that follows the input's rise. Before that edge it still reads 1. A wake-up input held high does not clear power-down again.
- R5: A write of 0 to bit 0 of the power-mode register clears power-down on the write edge, and the stopped branches restart. A write of 1 sets power-down on the write edge.
- R6: When a write of 1 to power-down and a detected wake-up edge fall on the same clock edge, power-down ends at 0.
- R7: The status register sits at byte offset 0x4. Bit j (j < NUM_BASE) is 1 when at least one effective branch enable of base j was 1 at the previous clock edge, and 0 when all of them were 0. The status bits are taken from the effective enables, not from the run bits. Bits NUM_BASE and up read 0.
- R8: During reset all NUM_BASE status bits read 1. Writes to offset 0x4 have no effect.
- R9: Reset leaves power-down at 0. Any offset other than 0x0 and 0x4 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_addr_i | input | ADDR_W | Byte address of the register access |
| bus_wdata_i | input | DATA_W | Write data |
| bus_we_i | input | 1 | Write strobe, sampled on the clock edge |
| bus_rdata_o | output | DATA_W | Read data for bus_addr_i, combinational |
| br_run_i | input | NUM_BASE*BR_PER_BASE | Run request for each branch |
| br_wake_en_i | input | NUM_BASE*BR_PER_BASE | Wake-up option for each branch |
| wake_irq_i | input | 1 | Asynchronous wake-up interrupt, acts on its rising edge |
| br_en_o | output | NUM_BASE*BR_PER_BASE | Effective enable for each branch |

## Verification
The hardest case to reach from the ports is a power-down write landing on the very edge where the wake-up event is active. That event is internal and shows up only two clock edges after the interrupt pin rises. The bench counts clock edges from the moment it raises the pin and asserts the write strobe in the cycle that ends on the third edge. It then reads power-down back, and a second write with the pin still high shows that no second event follows. A further hard case is a base whose branches all request a clock but have all been stopped by power-down. The bench builds this case so that the status bit is seen to drop while the run bits stay set.

// File: rtl/brpd_pkg.sv
package brpd_pkg;
  localparam int unsigned PM_OFF   = 32'h0;
  localparam int unsigned STAT_OFF = 32'h4;

  typedef enum logic [1:0] {
    SEL_NONE,
    SEL_PM,
    SEL_STAT
  } reg_sel_e;
endpackage

// File: rtl/brpd_wake_sync.sv
module brpd_wake_sync #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic irq_i,
  output logic evt_o
);
  localparam int unsigned MSB = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;

  generate
    if (SYNC_STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sync_q <= '0;
        else         sync_q <= irq_i;
    end else begin : g_chain
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sync_q <= '0;
        else         sync_q <= {sync_q[SYNC_STAGES-2:0], irq_i};
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= sync_q[MSB];

  assign evt_o = sync_q[MSB] & ~prev_q;

  // R4: edge detect yields single-cycle pulses
  a_r4_evt_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_o |=> !evt_o);
endmodule

// File: rtl/brpd_mode_reg.sv
module brpd_mode_reg (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wr_i,
  input  logic wdata_i,
  input  logic wake_evt_i,
  output logic pd_o
);
  logic pd_q;

  // wake-up wins over a same-cycle write
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)         pd_q <= 1'b0;
    else if (wake_evt_i) pd_q <= 1'b0;
    else if (wr_i)       pd_q <= wdata_i;

  assign pd_o = pd_q;

  a_r4_wake_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_evt_i |=> !pd_o);
  a_r6_wake_beats_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wake_evt_i && wr_i && wdata_i) |=> !pd_o);
  a_r5_write_takes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !wake_evt_i) |=> (pd_o == $past(wdata_i)));
  a_r5_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_i && !wake_evt_i) |=> $stable(pd_o));
endmodule

// File: rtl/brpd_branch_gate.sv
module brpd_branch_gate #(
  parameter int unsigned NUM_BR = 52
) (
  input  logic [NUM_BR-1:0] run_i,
  input  logic [NUM_BR-1:0] wake_en_i,
  input  logic              pd_i,
  output logic [NUM_BR-1:0] en_o
);
  generate
    for (genvar b = 0; b < NUM_BR; b++) begin : g_br
      assign en_o[b] = run_i[b] & ~(pd_i & wake_en_i[b]);
    end
  endgenerate
endmodule

// File: rtl/brpd_base_status.sv
module brpd_base_status #(
  parameter int unsigned NUM_BASE    = 13,
  parameter int unsigned BR_PER_BASE = 4
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic [NUM_BASE*BR_PER_BASE-1:0]   en_i,
  output logic [NUM_BASE-1:0]               stat_o
);
  logic [NUM_BASE-1:0] stat_q;

  generate
    for (genvar j = 0; j < NUM_BASE; j++) begin : g_base
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stat_q[j] <= 1'b1;
        else         stat_q[j] <= |en_i[j*BR_PER_BASE +: BR_PER_BASE];

      // R7: a zero status bit means every branch of the base was off
      a_r7_zero_means_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !stat_q[j] |-> ($past(en_i[j*BR_PER_BASE +: BR_PER_BASE]) == '0));
    end
  endgenerate

  assign stat_o = stat_q;
endmodule

// File: rtl/brclk_pwrdn_ctrl.sv
module brclk_pwrdn_ctrl
  import brpd_pkg::*;
#(
  parameter int unsigned NUM_BASE    = 13,
  parameter int unsigned BR_PER_BASE = 4,
  parameter int unsigned ADDR_W      = 8,
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic [ADDR_W-1:0]               bus_addr_i,
  input  logic [DATA_W-1:0]               bus_wdata_i,
  input  logic                            bus_we_i,
  output logic [DATA_W-1:0]               bus_rdata_o,
  input  logic [NUM_BASE*BR_PER_BASE-1:0] br_run_i,
  input  logic [NUM_BASE*BR_PER_BASE-1:0] br_wake_en_i,
  input  logic                            wake_irq_i,
  output logic [NUM_BASE*BR_PER_BASE-1:0] br_en_o
);
  localparam int unsigned NUM_BR = NUM_BASE * BR_PER_BASE;

  reg_sel_e            sel;
  logic                pm_wr;
  logic                wake_evt;
  logic                pd;
  logic [NUM_BASE-1:0] stat;
  logic                unused_wdata;

  assign unused_wdata = ^bus_wdata_i[DATA_W-1:1];

  always_comb begin
    sel = SEL_NONE;
    if (bus_addr_i == ADDR_W'(PM_OFF))        sel = SEL_PM;
    else if (bus_addr_i == ADDR_W'(STAT_OFF)) sel = SEL_STAT;
  end

  assign pm_wr = bus_we_i && (sel == SEL_PM);

  brpd_wake_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .irq_i (wake_irq_i),
    .evt_o (wake_evt)
  );

  brpd_mode_reg u_mode (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_i      (pm_wr),
    .wdata_i   (bus_wdata_i[0]),
    .wake_evt_i(wake_evt),
    .pd_o      (pd)
  );

  brpd_branch_gate #(.NUM_BR(NUM_BR)) u_gate (
    .run_i    (br_run_i),
    .wake_en_i(br_wake_en_i),
    .pd_i     (pd),
    .en_o     (br_en_o)
  );

  brpd_base_status #(.NUM_BASE(NUM_BASE), .BR_PER_BASE(BR_PER_BASE)) u_stat (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (br_en_o),
    .stat_o(stat)
  );

  always_comb begin
    unique case (sel)
      SEL_PM:   bus_rdata_o = DATA_W'(pd);
      SEL_STAT: bus_rdata_o = DATA_W'(stat);
      default:  bus_rdata_o = '0;
    endcase
  end

  a_r2_gated_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pd |-> ((br_wake_en_i & br_en_o) == '0));
  a_r2_unflagged_run: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pd |-> ((~br_wake_en_i & br_en_o) == (~br_wake_en_i & br_run_i)));
  a_r3_normal_run: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pd |-> (br_en_o == br_run_i));
endmodule

// File: tb/brclk_pwrdn_ctrl_tb_top.sv
module brclk_pwrdn_ctrl_tb_top;
  localparam int NB = 13, BPB = 4, NBR = NB * BPB, AW = 8, DW = 32;

  logic           clk = 1'b0;
  logic           rst_n;
  logic [AW-1:0]  bus_addr;
  logic [DW-1:0]  bus_wdata;
  logic           bus_we;
  logic [DW-1:0]  bus_rdata;
  logic [NBR-1:0] run, wk, br_en;
  logic           wake;

  always #10 clk = ~clk;

  brclk_pwrdn_ctrl #(.NUM_BASE(NB), .BR_PER_BASE(BPB), .ADDR_W(AW), .DATA_W(DW)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .bus_addr_i(bus_addr), .bus_wdata_i(bus_wdata),
    .bus_we_i(bus_we), .bus_rdata_o(bus_rdata), .br_run_i(run), .br_wake_en_i(wk),
    .wake_irq_i(wake), .br_en_o(br_en)
  );

  typedef struct {
    bit          is_reg;
    logic [63:0] exp;
    string       tag;
  } sb_item_t;

  sb_item_t sb_q[$];
  int checks = 0, fails = 0;
  bit done = 1'b0;

  // monitor: compares queued expectations shortly after each falling edge
  initial forever begin
    @(negedge clk);
    #2;
    while (sb_q.size() > 0) begin
      sb_item_t it;
      logic [63:0] act;
      it = sb_q.pop_front();
      act = it.is_reg ? 64'(bus_rdata) : 64'(br_en);
      checks++;
      if (act !== it.exp) begin
        fails++;
        $display("FAIL %s act=%h exp=%h", it.tag, act, it.exp);
      end
    end
  end

  function automatic logic [NBR-1:0] m_en(logic [NBR-1:0] r, logic [NBR-1:0] w, bit p);
    return r & ~(p ? w : '0);
  endfunction

  function automatic logic [63:0] m_stat(logic [NBR-1:0] en);
    logic [63:0] s = '0;
    for (int j = 0; j < NB; j++) s[j] = |en[j*BPB +: BPB];
    return s;
  endfunction

  task automatic expect_reg(input logic [AW-1:0] a, input logic [63:0] e, input string tag);
    @(negedge clk);
    bus_addr = a;
    sb_q.push_back('{1'b1, e, tag});
    #4;
  endtask

  task automatic expect_en(input logic [63:0] e, input string tag);
    @(negedge clk);
    sb_q.push_back('{1'b0, e, tag});
    #4;
  endtask

  task automatic bus_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  localparam logic [NBR-1:0] RUN_A = 52'h9_3C5A_E1B0_605F;
  localparam logic [NBR-1:0] WK_A  = 52'h0_F00A_1234_5F1F;

  initial begin
    rst_n = 1'b0; bus_addr = '0; bus_wdata = '0; bus_we = 1'b0;
    run = '0; wk = '0; wake = 1'b0;

    expect_reg(8'h0, 64'h0, "R9 power-down at reset");
    expect_reg(8'h4, 64'h1FFF, "R8 status all ones at reset");
    expect_reg(8'h8, 64'h0, "R9 unmapped offset reads zero");
    expect_en(64'h0, "R3 enables follow run at reset");

    @(negedge clk);
    rst_n = 1'b1; run = RUN_A; wk = WK_A;
    expect_en(64'(RUN_A), "R3 normal run");
    expect_reg(8'h4, m_stat(RUN_A), "R7 status from run");

    bus_write(8'h0, 32'hFFFF_FFFF);
    expect_reg(8'h0, 64'h1, "R1 only bit 0 kept");
    expect_en(64'(m_en(RUN_A, WK_A, 1'b1)), "R2 flagged branches stopped");
    expect_reg(8'h4, m_stat(m_en(RUN_A, WK_A, 1'b1)), "R7 gated base reads zero");

    bus_write(8'h4, 32'h0);
    expect_reg(8'h4, m_stat(m_en(RUN_A, WK_A, 1'b1)), "R8 status write ignored");
    expect_reg(8'h0, 64'h1, "R8 status write leaves mode");

    bus_write(8'h0, 32'h0);
    expect_reg(8'h0, 64'h0, "R5 write zero clears");
    expect_en(64'(RUN_A), "R5 branches restart");
    bus_write(8'h0, 32'h1);
    expect_reg(8'h0, 64'h1, "R5 write one sets");

    // wake-up latency
    @(negedge clk); wake = 1'b1;
    expect_reg(8'h0, 64'h1, "R4 held after first edge");
    expect_reg(8'h0, 64'h1, "R4 held after second edge");
    expect_reg(8'h0, 64'h0, "R4 cleared after third edge");
    expect_en(64'(RUN_A), "R4 branches restored");
    bus_write(8'h0, 32'h1);
    expect_reg(8'h0, 64'h1, "R4 level does not retrigger");
    @(negedge clk); wake = 1'b0;
    repeat (4) @(negedge clk);

    // write of one lands on the wake event edge
    wake = 1'b1;
    @(negedge clk);
    @(negedge clk);
    bus_addr = 8'h0; bus_wdata = 32'h1; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
    expect_reg(8'h0, 64'h0, "R6 wake beats write");
    bus_write(8'h0, 32'h1);
    expect_reg(8'h0, 64'h1, "R6 later write sets");
    @(negedge clk); wake = 1'b0;

    bus_write(8'h0, 32'hFFFF_FFFE);
    expect_reg(8'h0, 64'h0, "R1 upper bits ignored");

    bus_write(8'h0, 32'h1);
    @(negedge clk); run = '1; wk = '0;
    expect_en(64'(m_en('1, '0, 1'b1)), "R2 unflagged keep running");
    expect_reg(8'h4, 64'h1FFF, "R7 all bases running");
    @(negedge clk); run = '0;
    expect_reg(8'h4, 64'h0, "R7 all bases idle");

    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog act=running exp=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule